// File: doc/BRIEF.md
# Slave FIFO Bus Interface

This block lets an external bus master move data in and out of four endpoint FIFOs over a 16-bit parallel bus. The master drives a chip select, read and write strobes, an output enable, a packet-end strobe and a 2-bit endpoint address. The block answers with read data and with the empty, full and level flags of the addressed endpoint. A per-endpoint direction bit decides which side fills a buffer. IN endpoints are written by the external master and drained byte by byte through a simple USB-side pop port. OUT endpoints are filled through a USB-side push port and read by the external master.

Each endpoint carries its own width bit. In byte mode one transfer moves one byte. In word mode one transfer moves two bytes, low byte first. On IN endpoints, written bytes stay hidden from the USB side until a whole packet has built up or the master commits a short packet with the packet-end strobe. The control port works in one of two modes. In the clocked mode a strobe qualifies a transfer on each interface clock edge. In the strobe mode every assertion of a strobe causes exactly one transfer, after a two-flop synchronizer.

The strobe qualifier used in the strobe mode is a two-state machine. In QS_IDLE it waits for the synchronized strobe. The move QS_IDLE to QS_HELD fires the single transfer. In QS_HELD it waits for the strobe to drop, and the move QS_HELD to QS_IDLE re-arms it.

Top module: `sfifo_slave_if`

## Requirements
- R1: After reset every endpoint holds no data: flag_empty is 1, flag_full is 0, flag_level is 0, dout_en is 0 and usb_level is 0.
- R2: While sel is 0, wr_stb, rd_stb, pkt_end and oe have no effect: nothing is stored, committed or removed, and dout_en stays 0.
- R3: ep_addr (0 to 3) picks the endpoint that the external transfers and the three flags refer to.
- R4: With ep_word[n] = 1 a transfer moves two bytes: din[7:0] is the first byte and din[15:8] the second, and dout shows {second, first}. With ep_word[n] = 0 only din[7:0] is used and dout[15:8] is 0.
- R5: With async_mode = 0, every rising clock edge on which sel and a strobe are both 1 performs one transfer.
- R6: With async_mode = 1, each assertion of a strobe (while sel is 1) performs exactly one transfer. It takes effect on the third rising edge after the strobe rises, however long the strobe is held.
- R7: With unit = 2 bytes for a word endpoint and 1 byte otherwise: flag_empty = stored < unit, flag_full = (DEPTH - stored) < unit, flag_level = stored >= LEVEL_MARK (6 by default).
- R8: A write to an endpoint whose full flag is set and a read from an endpoint whose empty flag is set are ignored, and the stored data is not disturbed.
- R9: On an IN endpoint, written bytes become visible on usb_level and usb_rdata only when the uncommitted bytes reach PKT_BYTES (8 by default), or when pkt_end commits all of them.
- R10: ep_dir_in[n] = 1 marks an IN endpoint and 0 an OUT endpoint. External writes to OUT endpoints, external reads from IN endpoints, USB pushes into IN endpoints and USB pops from OUT endpoints are ignored.
- R11: usb_push stores usb_wdata in the OUT endpoint usb_ep if it is not full. usb_pop removes the committed head byte of the IN endpoint usb_ep. usb_rdata shows that head byte, and usb_level shows the committed byte count.
- R12: dout_en equals sel AND oe, and dout is 0 while dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset |
| async_mode | input | 1 | 1 selects strobe mode, 0 the clocked mode |
| ep_dir_in | input | 4 | Per-endpoint direction, 1 = IN (external master writes) |
| ep_word | input | 4 | Per-endpoint width, 1 = 16-bit transfers |
| sel | input | 1 | Chip select gating all strobes |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| oe | input | 1 | Output enable for dout |
| pkt_end | input | 1 | Commit a short packet on the addressed IN endpoint |
| ep_addr | input | 2 | Endpoint address for external transfers and flags |
| din | input | 16 | Write data |
| dout | output | 16 | Read data of the addressed endpoint |
| dout_en | output | 1 | dout is being driven |
| flag_empty | output | 1 | Addressed endpoint holds less than one transfer |
| flag_full | output | 1 | Addressed endpoint has room for less than one transfer |
| flag_level | output | 1 | Addressed endpoint holds at least LEVEL_MARK bytes |
| usb_ep | input | 2 | Endpoint for the USB-side port |
| usb_push | input | 1 | Push usb_wdata into an OUT endpoint |
| usb_wdata | input | 8 | USB-side write byte |
| usb_pop | input | 1 | Pop the head byte of an IN endpoint |
| usb_rdata | output | 8 | Committed head byte of usb_ep |
| usb_level | output | 5 | Committed byte count of usb_ep |

## Verification
The assertions take it that the master never raises the write strobe while it holds sel and oe together. They also take it that in strobe mode a strobe, once detected, produces one transfer and then stays quiet until it is released. The stimulus therefore issues writes only with oe low. In strobe mode it holds the address, the data and each strobe steady for several cycles, then leaves the strobe low long enough for the synchronizer to clear before the next pulse. The ignore checks drive the strobes only at times when the USB-side port is idle, so that no count changes for another reason.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/1ps
package sfifo_pkg;
    localparam int NUM_EP   = 4;
    localparam int EP_IDX_W = $clog2(NUM_EP);
    localparam int BYTE_W   = 8;
    localparam int BUS_W    = 2 * BYTE_W;
    localparam int STB_WR   = 0;
    localparam int STB_RD   = 1;
    localparam int STB_PK   = 2;
    localparam int NUM_STB  = 3;

    typedef enum logic {
        QS_IDLE = 1'b0,
        QS_HELD = 1'b1
    } qual_state_e;
endpackage

// File: rtl/sfifo_strobe.sv
`timescale 1ns/1ps
// Turns one gated control strobe into a single-cycle action request.
// Clocked mode passes the strobe through. Strobe mode synchronizes it
// and fires once per assertion.
module sfifo_strobe
    import sfifo_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_mode,
    input  logic raw,
    output logic act
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    qual_state_e            state_q, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
    end

    assign synced = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= QS_IDLE;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            QS_IDLE: if (synced)  state_nx = QS_HELD;
            QS_HELD: if (!synced) state_nx = QS_IDLE;
            default: state_nx = QS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        if (async_mode) act = (state_q == QS_IDLE) && synced;
        else            act = raw;
    end
endmodule

// File: rtl/sfifo_ep.sv
`timescale 1ns/1ps
// Byte-granular endpoint buffer with one write port, one read port and
// a committed region that the reader may consume.
module sfifo_ep
    import sfifo_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int PKT_BYTES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       auto_commit,
    input  logic                       wr_en,
    input  logic                       wr_two,
    input  logic [BUS_W-1:0]           wr_data,
    input  logic                       rd_en,
    input  logic                       rd_two,
    input  logic                       commit_req,
    output logic [BUS_W-1:0]           head_data,
    output logic [$clog2(DEPTH):0]     count,
    output logic [$clog2(DEPTH):0]     ready
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic [CW-1:0]     wadd, rsub, pend_nx, count_nx, ready_nx;
    logic              flush;

    assign wadd = wr_en ? (wr_two ? CW'(2) : CW'(1)) : '0;
    assign rsub = rd_en ? (rd_two ? CW'(2) : CW'(1)) : '0;

    always_comb begin
        pend_nx  = (count - ready) + wadd;
        flush    = auto_commit || commit_req || (pend_nx >= CW'(PKT_BYTES));
        count_nx = count + wadd - rsub;
        ready_nx = ready - rsub + (flush ? pend_nx : '0);
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wp] <= wr_data[BYTE_W-1:0];
            if (wr_two) mem[wp + ONE] <= wr_data[BUS_W-1:BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ready <= '0;
        end else begin
            wp    <= wp + wadd[AW-1:0];
            rp    <= rp + rsub[AW-1:0];
            count <= count_nx;
            ready <= ready_nx;
        end
    end

    assign head_data = {mem[rp + ONE], mem[rp]};
endmodule

// File: rtl/sfifo_slave_if.sv
`timescale 1ns/1ps
module sfifo_slave_if
    import sfifo_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int PKT_BYTES   = 8,
    parameter int LEVEL_MARK  = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     async_mode,
    input  logic [NUM_EP-1:0]        ep_dir_in,
    input  logic [NUM_EP-1:0]        ep_word,
    input  logic                     sel,
    input  logic                     rd_stb,
    input  logic                     wr_stb,
    input  logic                     oe,
    input  logic                     pkt_end,
    input  logic [EP_IDX_W-1:0]      ep_addr,
    input  logic [BUS_W-1:0]         din,
    output logic [BUS_W-1:0]         dout,
    output logic                     dout_en,
    output logic                     flag_empty,
    output logic                     flag_full,
    output logic                     flag_level,
    input  logic [EP_IDX_W-1:0]      usb_ep,
    input  logic                     usb_push,
    input  logic [BYTE_W-1:0]        usb_wdata,
    input  logic                     usb_pop,
    output logic [BYTE_W-1:0]        usb_rdata,
    output logic [$clog2(DEPTH):0]   usb_level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [NUM_STB-1:0]   raw, act;
    logic [CW-1:0]        cnt  [NUM_EP];
    logic [CW-1:0]        rdy  [NUM_EP];
    logic [BUS_W-1:0]     head [NUM_EP];
    logic [NUM_EP*CW-1:0] cnt_flat, rdy_flat;
    logic [CW-1:0]        cnt_sel, unit_sel;
    logic [BUS_W-1:0]     head_sel;
    logic                 ext_wr_ok, ext_rd_ok, pk_ok, usb_push_ok, usb_pop_ok;

    // chip select gates every control strobe
    assign raw[STB_WR] = sel & wr_stb;
    assign raw[STB_RD] = sel & rd_stb;
    assign raw[STB_PK] = sel & pkt_end;

    for (genvar s = 0; s < NUM_STB; s++) begin : g_stb
        sfifo_strobe #(.SYNC_STAGES(SYNC_STAGES)) stb_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .async_mode (async_mode),
            .raw        (raw[s]),
            .act        (act[s])
        );
    end

    // flags of the addressed endpoint
    always_comb begin
        cnt_sel    = cnt[ep_addr];
        head_sel   = head[ep_addr];
        unit_sel   = ep_word[ep_addr] ? CW'(2) : CW'(1);
        flag_empty = cnt_sel < unit_sel;
        flag_full  = (CW'(DEPTH) - cnt_sel) < unit_sel;
        flag_level = cnt_sel >= CW'(LEVEL_MARK);
    end

    // legality of each request
    always_comb begin
        ext_wr_ok   = act[STB_WR] &  ep_dir_in[ep_addr] & ~flag_full;
        ext_rd_ok   = act[STB_RD] & ~ep_dir_in[ep_addr] & ~flag_empty;
        pk_ok       = act[STB_PK] &  ep_dir_in[ep_addr];
        usb_push_ok = usb_push & ~ep_dir_in[usb_ep] & (cnt[usb_ep] != CW'(DEPTH));
        usb_pop_ok  = usb_pop  &  ep_dir_in[usb_ep] & (rdy[usb_ep] != '0);
    end

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        logic hit_ext, hit_usb;
        assign hit_ext = (ep_addr == EP_IDX_W'(g));
        assign hit_usb = (usb_ep  == EP_IDX_W'(g));

        sfifo_ep #(.DEPTH(DEPTH), .PKT_BYTES(PKT_BYTES)) ep_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .auto_commit (~ep_dir_in[g]),
            .wr_en       (ep_dir_in[g] ? (ext_wr_ok & hit_ext) : (usb_push_ok & hit_usb)),
            .wr_two      (ep_dir_in[g] & ep_word[g]),
            .wr_data     (ep_dir_in[g] ? din : {{BYTE_W{1'b0}}, usb_wdata}),
            .rd_en       (ep_dir_in[g] ? (usb_pop_ok & hit_usb) : (ext_rd_ok & hit_ext)),
            .rd_two      (~ep_dir_in[g] & ep_word[g]),
            .commit_req  (pk_ok & hit_ext),
            .head_data   (head[g]),
            .count       (cnt[g]),
            .ready       (rdy[g])
        );

        assign cnt_flat[g*CW +: CW] = cnt[g];
        assign rdy_flat[g*CW +: CW] = rdy[g];
    end

    always_comb begin
        dout_en = sel & oe;
        if (!dout_en)              dout = '0;
        else if (ep_word[ep_addr]) dout = head_sel;
        else                       dout = {{BYTE_W{1'b0}}, head_sel[BYTE_W-1:0]};
    end

    assign usb_rdata = head[usb_ep][BYTE_W-1:0];
    assign usb_level = rdy[usb_ep];
endmodule

// File: rtl/sfifo_slave_if_chk.sv
`timescale 1ns/1ps
module sfifo_slave_if_chk #(
    parameter int NUM_EP = 4,
    parameter int CW     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 async_mode,
    input logic                 sel,
    input logic                 oe,
    input logic                 wr_stb,
    input logic                 rd_stb,
    input logic                 pkt_end,
    input logic                 usb_push,
    input logic                 usb_pop,
    input logic                 flag_empty,
    input logic                 flag_full,
    input logic [2:0]           act,
    input logic [NUM_EP*CW-1:0] cnt_flat,
    input logic [NUM_EP*CW-1:0] rdy_flat
);
    // R12
    oe_idle_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && oe) |-> !wr_stb);

    // R7
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_empty && flag_full));

    // R6
    async_single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (async_mode && act[0]) |=> (!act[0] || !async_mode));

    // R2
    deselect_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_mode && !sel && !usb_push && !usb_pop) |=> $stable(cnt_flat));

    // R8
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_mode && sel && wr_stb && !rd_stb && !pkt_end && flag_full
         && !usb_push && !usb_pop) |=> $stable(cnt_flat));

    // R8
    empty_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_mode && sel && rd_stb && !wr_stb && !pkt_end && flag_empty
         && !usb_push && !usb_pop) |=> $stable(cnt_flat));

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep_chk
        // R9
        committed_within_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rdy_flat[g*CW +: CW] <= cnt_flat[g*CW +: CW]);
    end
endmodule

bind sfifo_slave_if sfifo_slave_if_chk #(.NUM_EP(NUM_EP), .CW(CW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_mode (async_mode),
    .sel        (sel),
    .oe         (oe),
    .wr_stb     (wr_stb),
    .rd_stb     (rd_stb),
    .pkt_end    (pkt_end),
    .usb_push   (usb_push),
    .usb_pop    (usb_pop),
    .flag_empty (flag_empty),
    .flag_full  (flag_full),
    .act        (act),
    .cnt_flat   (cnt_flat),
    .rdy_flat   (rdy_flat)
);

// File: tb/sfifo_slave_if_tb_top.sv
`timescale 1ns/1ps
module sfifo_slave_if_tb_top;
    localparam int DEPTH = 16;
    localparam int PKT   = 8;
    localparam int MARK  = 6;

    logic        clk = 1'b0;
    logic        rst_n, async_mode, sel, rd_stb, wr_stb, oe, pkt_end;
    logic [3:0]  ep_dir_in, ep_word;
    logic [1:0]  ep_addr, usb_ep;
    logic [15:0] din, dout;
    logic        dout_en, flag_empty, flag_full, flag_level;
    logic        usb_push, usb_pop;
    logic [7:0]  usb_wdata, usb_rdata;
    logic [4:0]  usb_level;

    int q [4][$];
    int comm [4];
    bit dir [4];
    bit wrd [4];
    bit af_wr, af_rd, af_pk, checking;
    int checks, errors;
    int last_pop;

    always #10 clk = ~clk;

    sfifo_slave_if dut_i (
        .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .ep_dir_in(ep_dir_in),
        .ep_word(ep_word), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb), .oe(oe),
        .pkt_end(pkt_end), .ep_addr(ep_addr), .din(din), .dout(dout), .dout_en(dout_en),
        .flag_empty(flag_empty), .flag_full(flag_full), .flag_level(flag_level),
        .usb_ep(usb_ep), .usb_push(usb_push), .usb_wdata(usb_wdata), .usb_pop(usb_pop),
        .usb_rdata(usb_rdata), .usb_level(usb_level)
    );

    task automatic chk(string req, int act_v, int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act_v, exp_v);
        end
    endtask

    // behavioural reference, applied on each rising edge
    task automatic model_step(bit ew, bit er, bit ek);
        int e, u, ue;
        int osz [4];
        int ocm [4];
        int wadd [4];
        int rsub [4];
        bit dw, dr, dup, duo;
        e  = int'(ep_addr);
        ue = int'(usb_ep);
        u  = wrd[e] ? 2 : 1;
        for (int j = 0; j < 4; j++) begin
            osz[j] = q[j].size(); ocm[j] = comm[j]; wadd[j] = 0; rsub[j] = 0;
        end
        dw  = ew && dir[e] && (DEPTH - osz[e] >= u);
        dr  = er && !dir[e] && (ocm[e] >= u);
        dup = usb_push && !dir[ue] && (osz[ue] < DEPTH);
        duo = usb_pop && dir[ue] && (ocm[ue] > 0);
        if (dw) begin
            q[e].push_back(int'(din[7:0]));
            if (u == 2) q[e].push_back(int'(din[15:8]));
            wadd[e] += u;
        end
        if (dup) begin
            q[ue].push_back(int'(usb_wdata));
            wadd[ue] += 1;
        end
        if (dr) begin
            for (int k = 0; k < u; k++) void'(q[e].pop_front());
            rsub[e] += u;
        end
        if (duo) begin
            void'(q[ue].pop_front());
            rsub[ue] += 1;
        end
        for (int j = 0; j < 4; j++) begin
            if (!dir[j]) comm[j] = q[j].size();
            else begin
                int np;
                np = osz[j] - ocm[j] + wadd[j];
                comm[j] = ocm[j] - rsub[j] + (((ek && dir[j] && j == e) || np >= PKT) ? np : 0);
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst_n === 1'b1)
            model_step((!async_mode && sel && wr_stb) || af_wr,
                       (!async_mode && sel && rd_stb) || af_rd,
                       (!async_mode && sel && pkt_end) || af_pk);
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (checking) begin
            int e, u, sz, ue, expd;
            e  = int'(ep_addr);
            ue = int'(usb_ep);
            u  = wrd[e] ? 2 : 1;
            sz = q[e].size();
            chk("R7 empty flag", int'(flag_empty), int'(sz < u));
            chk("R7 full flag", int'(flag_full), int'((DEPTH - sz) < u));
            chk("R7 level flag", int'(flag_level), int'(sz >= MARK));
            chk("R12 dout_en", int'(dout_en), int'(sel && oe));
            if (!(sel && oe)) chk("R12 dout idle", int'(dout), 0);
            else if (sz >= u) begin
                expd = (u == 2) ? (q[e][1] * 256 + q[e][0]) : q[e][0];
                chk("R4 dout value", int'(dout), expd);
            end
            chk("R11 usb_level", int'(usb_level), comm[ue]);
            if (comm[ue] > 0) chk("R11 usb_rdata", int'(usb_rdata), q[ue][0]);
        end
    end

    task automatic cyc();
        @(posedge clk);
        #4;
    endtask

    task automatic ext_write(int e, logic [15:0] d);
        ep_addr = 2'(e); sel = 1'b1; wr_stb = 1'b1; din = d;
        cyc();
        wr_stb = 1'b0; sel = 1'b0;
    endtask

    task automatic ext_read(int e);
        ep_addr = 2'(e); sel = 1'b1; oe = 1'b1; rd_stb = 1'b1;
        cyc();
        rd_stb = 1'b0; oe = 1'b0; sel = 1'b0;
    endtask

    task automatic commit_pkt(int e);
        ep_addr = 2'(e); sel = 1'b1; pkt_end = 1'b1;
        cyc();
        pkt_end = 1'b0; sel = 1'b0;
    endtask

    task automatic upush(int e, logic [7:0] b);
        usb_ep = 2'(e); usb_push = 1'b1; usb_wdata = b;
        cyc();
        usb_push = 1'b0;
    endtask

    task automatic upop(int e);
        usb_ep = 2'(e); #1;
        last_pop = int'(usb_rdata);
        usb_pop = 1'b1;
        cyc();
        usb_pop = 1'b0;
    endtask

    // kind: 0 write, 1 read, 2 packet end
    task automatic apulse(int kind, int e);
        ep_addr = 2'(e); sel = 1'b1;
        if (kind == 0) wr_stb = 1'b1;
        else if (kind == 1) rd_stb = 1'b1;
        else pkt_end = 1'b1;
        cyc();
        cyc();
        if (kind == 0) af_wr = 1'b1;
        else if (kind == 1) af_rd = 1'b1;
        else af_pk = 1'b1;
        cyc();
        af_wr = 1'b0; af_rd = 1'b0; af_pk = 1'b0;
        cyc();
        cyc();
        wr_stb = 1'b0; rd_stb = 1'b0; pkt_end = 1'b0; sel = 1'b0;
        repeat (4) cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        checks = 0; errors = 0; checking = 1'b0;
        af_wr = 1'b0; af_rd = 1'b0; af_pk = 1'b0;
        rst_n = 1'b0; async_mode = 1'b0; sel = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
        oe = 1'b0; pkt_end = 1'b0; ep_addr = '0; din = '0; usb_ep = '0;
        usb_push = 1'b0; usb_pop = 1'b0; usb_wdata = '0;
        ep_dir_in = 4'b0011;
        ep_word   = 4'b1010;
        for (int j = 0; j < 4; j++) begin
            dir[j] = ep_dir_in[j]; wrd[j] = ep_word[j]; comm[j] = 0;
        end
        repeat (3) @(posedge clk);
        #4;
        rst_n = 1'b1;
        cyc();
        checking = 1'b1;

        // R1 reset state
        chk("R1 empty", int'(flag_empty), 1);
        chk("R1 full", int'(flag_full), 0);
        chk("R1 level", int'(flag_level), 0);
        chk("R1 dout_en", int'(dout_en), 0);
        chk("R1 usb_level", int'(usb_level), 0);

        // R9 partial packet stays hidden, whole packet commits
        for (int i = 0; i < 5; i++) ext_write(0, 16'(8'h10 + i));
        usb_ep = 2'd0; #1;
        chk("R9 uncommitted hidden", int'(usb_level), 0);
        for (int i = 5; i < 8; i++) ext_write(0, 16'(8'h10 + i));
        chk("R9 full packet commits", int'(usb_level), 8);
        for (int i = 8; i < 16; i++) ext_write(0, 16'(8'h10 + i));
        ep_addr = 2'd0; #1;
        chk("R7 full at depth", int'(flag_full), 1);
        // R8 writes to a full endpoint are dropped
        ext_write(0, 16'h00EE);
        ext_write(0, 16'h00EF);
        chk("R8 no growth past full", int'(usb_level), 16);
        for (int i = 0; i < 16; i++) upop(0);
        chk("R8 last byte kept", last_pop, 8'h1F);

        // R9 packet end commits a short packet
        for (int i = 0; i < 3; i++) ext_write(0, 16'(8'h40 + i));
        commit_pkt(0);
        usb_ep = 2'd0; #1;
        chk("R9 short packet committed", int'(usb_level), 3);
        for (int i = 0; i < 3; i++) upop(0);

        // R4 word endpoint, low byte first
        ext_write(1, 16'hB2A1);
        ext_write(1, 16'hD4C3);
        commit_pkt(1);
        usb_ep = 2'd1; #1;
        chk("R4 word bytes committed", int'(usb_level), 4);
        chk("R4 low byte first", int'(usb_rdata), 8'hA1);
        for (int i = 0; i < 4; i++) upop(1);

        // R11 / R4 byte OUT endpoint read by the master
        for (int i = 0; i < 5; i++) upush(2, 8'(8'h50 + i));
        ep_addr = 2'd2; sel = 1'b1; oe = 1'b1; #1;
        chk("R4 byte dout", int'(dout), 16'h0050);
        chk("R12 dout_en on", int'(dout_en), 1);
        sel = 1'b0; oe = 1'b0;
        for (int i = 0; i < 5; i++) ext_read(2);
        ep_addr = 2'd2; #1;
        chk("R7 empty after drain", int'(flag_empty), 1);
        ext_read(2);
        upush(2, 8'h77);
        ep_addr = 2'd2; sel = 1'b1; oe = 1'b1; #1;
        chk("R8 read from empty ignored", int'(dout), 16'h0077);
        sel = 1'b0; oe = 1'b0;
        ext_read(2);

        // R4 / R7 word OUT endpoint
        upush(3, 8'h31); upush(3, 8'h32); upush(3, 8'h33);
        ep_addr = 2'd3; sel = 1'b1; oe = 1'b1; #1;
        chk("R7 not empty with 3 bytes", int'(flag_empty), 0);
        chk("R4 word dout", int'(dout), 16'h3231);
        sel = 1'b0; oe = 1'b0;
        ext_read(3);
        ep_addr = 2'd3; #1;
        chk("R7 one byte is empty for word", int'(flag_empty), 1);
        ext_read(3);
        upush(3, 8'h34);
        ep_addr = 2'd3; sel = 1'b1; oe = 1'b1; #1;
        chk("R8 word read from empty ignored", int'(dout), 16'h3433);
        sel = 1'b0; oe = 1'b0;
        ext_read(3);

        // R10 wrong-direction requests are ignored
        ext_write(2, 16'h00AA);
        ep_addr = 2'd2; #1;
        chk("R10 write to OUT ignored", int'(flag_empty), 1);
        upush(0, 8'hAB);
        ep_addr = 2'd0; usb_ep = 2'd0; #1;
        chk("R10 push to IN ignored", int'(flag_empty), 1);

        // R2 deselected strobes have no effect
        ep_addr = 2'd0; sel = 1'b0; wr_stb = 1'b1; din = 16'h0055;
        repeat (3) cyc();
        wr_stb = 1'b0; pkt_end = 1'b1;
        cyc();
        pkt_end = 1'b0; oe = 1'b1; #1;
        chk("R2 no write while deselected", int'(flag_empty), 1);
        chk("R2 dout_en while deselected", int'(dout_en), 0);
        oe = 1'b0;

        // R3 address selects the flag source
        ext_write(0, 16'h0099);
        ep_addr = 2'd0; #1;
        chk("R3 ep0 holds data", int'(flag_empty), 0);
        ep_addr = 2'd2; #1;
        chk("R3 ep2 still empty", int'(flag_empty), 1);

        // R5 back-to-back clocked writes
        ep_addr = 2'd0; sel = 1'b1; wr_stb = 1'b1;
        for (int i = 0; i < 6; i++) begin
            din = 16'(8'hC0 + i);
            cyc();
        end
        wr_stb = 1'b0; sel = 1'b0; #1;
        chk("R5 level after burst", int'(flag_level), 1);
        commit_pkt(0);
        usb_ep = 2'd0; #1;
        chk("R5 one byte per edge", int'(usb_level), 7);
        for (int i = 0; i < 7; i++) upop(0);

        // R6 strobe mode: one transfer per assertion
        async_mode = 1'b1;
        repeat (3) cyc();
        din = 16'h00E5;
        apulse(0, 0);
        apulse(2, 0);
        usb_ep = 2'd0; #1;
        chk("R6 single write per strobe", int'(usb_level), 1);
        chk("R6 written byte", int'(usb_rdata), 8'hE5);
        upop(0);
        upush(2, 8'h61); upush(2, 8'h62);
        apulse(1, 2);
        ep_addr = 2'd2; sel = 1'b1; oe = 1'b1; #1;
        chk("R6 single read per strobe", int'(dout), 16'h0062);
        chk("R6 one byte remains", int'(flag_empty), 0);
        sel = 1'b0; oe = 1'b0;
        repeat (3) cyc();

        checking = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule